// File: doc/BRIEF.md
# Qualified event readout word builder

When an event is accepted, this block turns one snapshot of a detector card's results into a sequence of 32-bit readout words and writes them into an output FIFO. The snapshot holds the hit pattern (shield pairs and detector channels), two energies, a crossover time and a fast-trigger time for each detector channel, an energy and a time for the shield, and per-channel veto, pre-pulse pileup and post-pulse pileup flags. Each word carries a 2-bit qualifier, a 6-bit item number, an 8-bit group number from configuration and a 16-bit payload.

The qualifier is computed from the flags, and its meaning depends on the kind of word. For energies it reports veto and pileup. For crossover times it reports which pileup occurred. Fast-trigger times always carry 00 and shield words always carry 11. A per-item enable mask chooses which words are written. The sequencer visits every item once, one per clock cycle, in ascending item order. If the FIFO reports full when a word is due, that word is lost and a sticky error flag is raised. A flush control bit clears the flag.

Item map for `NUM_DET` channels: item 0 is the pattern. Channel c (A = 0) owns items 1+4c (wide-range energy), 2+4c (narrow-range energy), 3+4c (crossover time) and 4+4c (fast-trigger time). Shield energy is item 1+4·NUM_DET and shield time is item 2+4·NUM_DET.

Top module: `evword_builder`

## Requirements
- R1: A written word is {qualifier[31:30], item[29:24], group[23:16], payload[15:0]}, where group is `groupId` as it stood on the clock edge that emitted the word.
- R2: The pattern word (item 0) has payload bits 7..0 equal to shield pairs 8..1 (pair 1 at bit 0), bits 12..8 equal to detector channels E..A (A at bit 8), bits 15..13 zero, and qualifier 00.
- R3: Every energy and time word carries its 13-bit value in payload bits 12..0, with bits 15..13 zero.
- R4: Both energy words of a detector channel carry qualifier 00 when the channel is clean, 01 for veto only, 10 for pileup (pre or post) only, and 11 for pileup together with veto.
- R5: A crossover-time word carries qualifier 00 for no pileup, 01 for post-pulse pileup only, 10 for pre-pulse pileup only, and 11 for both.
- R6: A fast-trigger time word always carries qualifier 00.
- R7: Shield energy and shield time words always carry qualifier 11.
- R8: When `evtValid` is seen while idle, `busy` rises on that edge. Item k is decided on the (k+1)th following edge, so items appear in ascending order with the pattern first. `busy` falls on the edge that decides the last item.
- R9: A word is written only if its bit in `rdEnable` (bit index = item number) is 1. A disabled item still uses its cycle but writes nothing.
- R10: If `fifoFull` is high on the edge that decides an enabled item, nothing is written and `overflowErr` is set. The flag stays set until a cycle with `fifoFlush` high clears it.
- R11: `evtValid` pulses while `busy` are ignored, and all payloads and flags come from the snapshot taken on the accepting edge, even if the inputs change during the event.
- R12: After reset, `busy`, `fifoWrEn` and `overflowErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtValid | input | 1 | Request to accept an event snapshot |
| shieldHit | input | NUM_SHIELD | Shield pair hit bits, pair 1 at bit 0 |
| detHit | input | NUM_DET | Detector channel hit bits, channel A at bit 0 |
| detWideE | input | NUM_DET×13 | Wide-range energy per channel |
| detNarrowE | input | NUM_DET×13 | Narrow-range energy per channel |
| detCrossT | input | NUM_DET×13 | Crossover time per channel |
| detFastT | input | NUM_DET×13 | Fast-trigger time per channel |
| shieldE | input | 13 | Shield energy |
| shieldT | input | 13 | Shield time |
| detVeto | input | NUM_DET | Anti-Compton veto per channel |
| detPrePile | input | NUM_DET | Pre-pulse pileup per channel |
| detPostPile | input | NUM_DET | Post-pulse pileup per channel |
| groupId | input | 8 | Group number placed in every word |
| rdEnable | input | 3+4·NUM_DET | Per-item readout enable |
| fifoFlush | input | 1 | Clears the overflow flag |
| fifoFull | input | 1 | Output FIFO cannot take a word |
| busy | output | 1 | An event is being sequenced |
| overflowErr | output | 1 | Sticky flag for a dropped word |
| fifoWrEn | output | 1 | FIFO write strobe |
| fifoWrData | output | 32 | FIFO write word |

## Verification
The first eight events rotate the veto/pre/post flag combinations across the channels so that every channel meets all eight combinations. This separates the energy qualifier encoding from the crossover encoding, and one event uses all-ones and all-zero values to expose any spill into bits 15..13. Alternating, single-item and empty enable masks show that a disabled item really skips its write while the order and slot timing of the other items stay fixed. A run with the FIFO held full, followed by a normal run and then a flush, separates "dropped" from "written", and "sticky" from "cleared". A second `evtValid` with different inputs in the middle of an event checks that the snapshot taken at acceptance is the one that gets written out.

// File: rtl/evword_pkg.sv
package evword_pkg;
  localparam int ITEM_W  = 6;
  localparam int GROUP_W = 8;
  localparam int VAL_W   = 13;
  localparam int PAY_W   = 16;
  localparam int QUAL_W  = 2;
  localparam int WORD_W  = QUAL_W + ITEM_W + GROUP_W + PAY_W;

  localparam logic [QUAL_W-1:0] QUAL_SHIELD = 2'b11;
  localparam logic [QUAL_W-1:0] QUAL_ZERO   = 2'b00;

  // Per-channel item kinds, in slot order inside a channel's group of four.
  typedef enum logic [1:0] {
    KIND_WIDE_E   = 2'd0,
    KIND_NARROW_E = 2'd1,
    KIND_CROSS_T  = 2'd2,
    KIND_FAST_T   = 2'd3
  } itemKind_e;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic              capture;
    logic              emit;
    logic [ITEM_W-1:0] item;
  } ctrlStrobe_t;
endpackage

// File: rtl/evword_control.sv
module evword_control
  import evword_pkg::*;
#(
  parameter int NUM_ITEMS = 23
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 evtValid,
  input  logic [NUM_ITEMS-1:0] rdEnable,
  input  logic                 fifoFull,
  input  logic                 fifoFlush,
  output ctrlStrobe_t          strobe,
  output logic                 busy,
  output logic                 overflowErr
);
  localparam int IDX_W = $clog2(NUM_ITEMS);
  localparam logic [ITEM_W-1:0] LAST_ITEM = ITEM_W'(NUM_ITEMS - 1);

  logic [ITEM_W-1:0] itemCnt;
  logic              itemEn;
  logic              dropNow;

  assign itemEn  = rdEnable[IDX_W'(itemCnt)];
  assign dropNow = busy && itemEn && fifoFull;

  always_comb begin
    strobe.capture = !busy && evtValid;
    strobe.emit    = busy && itemEn && !fifoFull;
    strobe.item    = itemCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      itemCnt <= '0;
    end else if (!busy) begin
      if (evtValid) begin
        busy    <= 1'b1;
        itemCnt <= '0;
      end
    end else begin
      if (itemCnt == LAST_ITEM) busy <= 1'b0;
      itemCnt <= itemCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          overflowErr <= 1'b0;
    else if (fifoFlush) overflowErr <= 1'b0;
    else if (dropNow)   overflowErr <= 1'b1;
  end
endmodule

// File: rtl/evword_datapath.sv
module evword_datapath
  import evword_pkg::*;
#(
  parameter int NUM_DET    = 5,
  parameter int NUM_SHIELD = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrlStrobe_t                     strobe,
  input  logic [NUM_SHIELD-1:0]           shieldHit,
  input  logic [NUM_DET-1:0]              detHit,
  input  logic [NUM_DET-1:0][VAL_W-1:0]   detWideE,
  input  logic [NUM_DET-1:0][VAL_W-1:0]   detNarrowE,
  input  logic [NUM_DET-1:0][VAL_W-1:0]   detCrossT,
  input  logic [NUM_DET-1:0][VAL_W-1:0]   detFastT,
  input  logic [VAL_W-1:0]                shieldE,
  input  logic [VAL_W-1:0]                shieldT,
  input  logic [NUM_DET-1:0]              detVeto,
  input  logic [NUM_DET-1:0]              detPrePile,
  input  logic [NUM_DET-1:0]              detPostPile,
  input  logic [GROUP_W-1:0]              groupId,
  output logic                            fifoWrEn,
  output logic [WORD_W-1:0]               fifoWrData
);
  localparam int CH_W        = $clog2(NUM_DET);
  localparam int SHIELD_E_IT = 1 + 4 * NUM_DET;

  // Snapshot taken on the accepting edge.
  logic [NUM_SHIELD-1:0]         capShieldHit;
  logic [NUM_DET-1:0]            capDetHit;
  logic [NUM_DET-1:0][VAL_W-1:0] capWideE, capNarrowE, capCrossT, capFastT;
  logic [VAL_W-1:0]              capShieldE, capShieldT;
  logic [NUM_DET-1:0]            capVeto, capPre, capPost;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capShieldHit <= '0; capDetHit <= '0;
      capWideE <= '0; capNarrowE <= '0; capCrossT <= '0; capFastT <= '0;
      capShieldE <= '0; capShieldT <= '0;
      capVeto <= '0; capPre <= '0; capPost <= '0;
    end else if (strobe.capture) begin
      capShieldHit <= shieldHit; capDetHit <= detHit;
      capWideE <= detWideE; capNarrowE <= detNarrowE;
      capCrossT <= detCrossT; capFastT <= detFastT;
      capShieldE <= shieldE; capShieldT <= shieldT;
      capVeto <= detVeto; capPre <= detPrePile; capPost <= detPostPile;
    end
  end

  // Per-channel qualifier encoders.
  logic [NUM_DET-1:0][QUAL_W-1:0] energyQual, crossQual;
  for (genvar c = 0; c < NUM_DET; c++) begin : g_qual
    assign energyQual[c] = {capPre[c] | capPost[c], capVeto[c]};
    assign crossQual[c]  = {capPre[c], capPost[c]};
  end

  // Word selection for the current item.
  logic [ITEM_W-1:0] rel;
  logic [CH_W-1:0]   chIdx;
  itemKind_e         kind;
  logic [QUAL_W-1:0] qual;
  logic [PAY_W-1:0]  payload;

  always_comb begin
    rel     = strobe.item - 1'b1;
    chIdx   = CH_W'(rel >> 2);
    kind    = itemKind_e'(rel[1:0]);
    qual    = QUAL_ZERO;
    payload = '0;
    if (strobe.item == '0) begin
      payload = PAY_W'({capDetHit, capShieldHit});
    end else if (int'(strobe.item) < SHIELD_E_IT) begin
      unique case (kind)
        KIND_WIDE_E:   begin payload = PAY_W'(capWideE[chIdx]);   qual = energyQual[chIdx]; end
        KIND_NARROW_E: begin payload = PAY_W'(capNarrowE[chIdx]); qual = energyQual[chIdx]; end
        KIND_CROSS_T:  begin payload = PAY_W'(capCrossT[chIdx]);  qual = crossQual[chIdx];  end
        KIND_FAST_T:   begin payload = PAY_W'(capFastT[chIdx]);   qual = QUAL_ZERO;         end
        default:       begin payload = '0;                        qual = QUAL_ZERO;         end
      endcase
    end else if (int'(strobe.item) == SHIELD_E_IT) begin
      payload = PAY_W'(capShieldE);
      qual    = QUAL_SHIELD;
    end else begin
      payload = PAY_W'(capShieldT);
      qual    = QUAL_SHIELD;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoWrEn   <= 1'b0;
      fifoWrData <= '0;
    end else begin
      fifoWrEn <= strobe.emit;
      if (strobe.emit) fifoWrData <= {qual, strobe.item, groupId, payload};
    end
  end
endmodule

// File: rtl/evword_builder.sv
module evword_builder
  import evword_pkg::*;
#(
  parameter int NUM_DET    = 5,
  parameter int NUM_SHIELD = 8
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic                                      evtValid,
  input  logic [NUM_SHIELD-1:0]                     shieldHit,
  input  logic [NUM_DET-1:0]                        detHit,
  input  logic [NUM_DET-1:0][evword_pkg::VAL_W-1:0] detWideE,
  input  logic [NUM_DET-1:0][evword_pkg::VAL_W-1:0] detNarrowE,
  input  logic [NUM_DET-1:0][evword_pkg::VAL_W-1:0] detCrossT,
  input  logic [NUM_DET-1:0][evword_pkg::VAL_W-1:0] detFastT,
  input  logic [evword_pkg::VAL_W-1:0]              shieldE,
  input  logic [evword_pkg::VAL_W-1:0]              shieldT,
  input  logic [NUM_DET-1:0]                        detVeto,
  input  logic [NUM_DET-1:0]                        detPrePile,
  input  logic [NUM_DET-1:0]                        detPostPile,
  input  logic [evword_pkg::GROUP_W-1:0]            groupId,
  input  logic [3+4*NUM_DET-1:0]                    rdEnable,
  input  logic                                      fifoFlush,
  input  logic                                      fifoFull,
  output logic                                      busy,
  output logic                                      overflowErr,
  output logic                                      fifoWrEn,
  output logic [evword_pkg::WORD_W-1:0]             fifoWrData
);
  localparam int NUM_ITEMS = 3 + 4 * NUM_DET;

  ctrlStrobe_t strobe;

  evword_control #(.NUM_ITEMS(NUM_ITEMS)) i_control (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .rdEnable(rdEnable),
    .fifoFull(fifoFull), .fifoFlush(fifoFlush), .strobe(strobe),
    .busy(busy), .overflowErr(overflowErr)
  );

  evword_datapath #(.NUM_DET(NUM_DET), .NUM_SHIELD(NUM_SHIELD)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .shieldHit(shieldHit), .detHit(detHit),
    .detWideE(detWideE), .detNarrowE(detNarrowE),
    .detCrossT(detCrossT), .detFastT(detFastT),
    .shieldE(shieldE), .shieldT(shieldT),
    .detVeto(detVeto), .detPrePile(detPrePile), .detPostPile(detPostPile),
    .groupId(groupId), .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData)
  );
endmodule

// File: rtl/evword_checker.sv
module evword_checker #(
  parameter int NUM_DET = 5
) (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        fifoFull,
  input logic        fifoFlush,
  input logic        overflowErr,
  input logic [7:0]  groupId,
  input logic        fifoWrEn,
  input logic [31:0] fifoWrData
);
  localparam int NUM_ITEMS   = 3 + 4 * NUM_DET;
  localparam int SHIELD_E_IT = 1 + 4 * NUM_DET;

  logic [5:0] itemF;
  logic [1:0] slotF;
  logic       isChanItem;
  assign itemF      = fifoWrData[29:24];
  assign slotF      = 2'(itemF - 6'd1);
  assign isChanItem = (itemF != 6'd0) && (int'(itemF) < SHIELD_E_IT);

  p_group_field_r1: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> fifoWrData[23:16] == $past(groupId));

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn && itemF != 6'd0 |-> fifoWrData[15:13] == 3'b000);

  p_fast_qual_r6: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn && isChanItem && slotF == 2'd3 |-> fifoWrData[31:30] == 2'b00);

  p_shield_qual_r7: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn && int'(itemF) >= SHIELD_E_IT |-> fifoWrData[31:30] == 2'b11);

  p_item_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> int'(itemF) < NUM_ITEMS);

  p_write_in_event_r8: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> $past(busy));

  p_item_ascends_r8: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn && $past(fifoWrEn) |-> itemF == 6'($past(fifoWrData[29:24]) + 6'd1));

  p_no_write_full_r10: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> $past(!fifoFull));

  p_sticky_err_r10: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr && !fifoFlush |=> overflowErr);
endmodule

bind evword_builder evword_checker #(.NUM_DET(NUM_DET)) i_checker (
  .clk(clk), .rstN(rstN), .busy(busy), .fifoFull(fifoFull),
  .fifoFlush(fifoFlush), .overflowErr(overflowErr), .groupId(groupId),
  .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData)
);

// File: tb/test_evword_builder.sv
module test_evword_builder;
  localparam int N  = 5;
  localparam int S  = 8;
  localparam int NI = 3 + 4 * N;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                rstN, evtValid, fifoFlush, fifoFull;
  logic [S-1:0]        shieldHit;
  logic [N-1:0]        detHit, detVeto, detPrePile, detPostPile;
  logic [N-1:0][12:0]  detWideE, detNarrowE, detCrossT, detFastT;
  logic [12:0]         shieldE, shieldT;
  logic [7:0]          groupId;
  logic [NI-1:0]       rdEnable;
  logic                busy, overflowErr, fifoWrEn;
  logic [31:0]         fifoWrData;

  // Reference snapshot the expected words are computed from.
  logic [S-1:0]        rShield;
  logic [N-1:0]        rDet, rVeto, rPre, rPost;
  logic [N-1:0][12:0]  rWide, rNarrow, rCross, rFast;
  logic [12:0]         rSE, rST;

  int checks = 0, fails = 0;

  evword_builder #(.NUM_DET(N), .NUM_SHIELD(S)) i_evword_builder (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .shieldHit(shieldHit),
    .detHit(detHit), .detWideE(detWideE), .detNarrowE(detNarrowE),
    .detCrossT(detCrossT), .detFastT(detFastT), .shieldE(shieldE),
    .shieldT(shieldT), .detVeto(detVeto), .detPrePile(detPrePile),
    .detPostPile(detPostPile), .groupId(groupId), .rdEnable(rdEnable),
    .fifoFlush(fifoFlush), .fifoFull(fifoFull), .busy(busy),
    .overflowErr(overflowErr), .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(input int it);
    logic [1:0]  q;
    logic [15:0] p;
    int c, k;
    q = 2'b00; p = '0;
    if (it == 0) begin
      p = 16'({rDet, rShield});
    end else if (it <= 4 * N) begin
      c = (it - 1) / 4; k = (it - 1) % 4;
      case (k)
        0: begin p = 16'(rWide[c]);   q = {rPre[c] | rPost[c], rVeto[c]}; end
        1: begin p = 16'(rNarrow[c]); q = {rPre[c] | rPost[c], rVeto[c]}; end
        2: begin p = 16'(rCross[c]);  q = {rPre[c], rPost[c]}; end
        default: begin p = 16'(rFast[c]); q = 2'b00; end
      endcase
    end else if (it == 4 * N + 1) begin
      p = 16'(rSE); q = 2'b11;
    end else begin
      p = 16'(rST); q = 2'b11;
    end
    return {q, 6'(it), groupId, p};
  endfunction

  function automatic string reqOf(input int it);
    int k;
    if (it == 0) return "R2";
    if (it > 4 * N) return "R7";
    k = (it - 1) % 4;
    if (k == 2) return "R5";
    if (k == 3) return "R6";
    return "R4";
  endfunction

  task automatic fillRef(input int seed);
    for (int c = 0; c < N; c++) begin
      int combo;
      combo      = (seed + c) % 8;
      rVeto[c]   = combo[0];
      rPre[c]    = combo[1];
      rPost[c]   = combo[2];
      rWide[c]   = 13'(seed * 811 + c * 97 + 3);
      rNarrow[c] = 13'(seed * 523 + c * 211 + 7);
      rCross[c]  = 13'(seed * 331 + c * 53 + 11);
      rFast[c]   = 13'(seed * 149 + c * 401 + 13);
    end
    rShield = 8'(1 << (seed % 8)) ^ 8'(seed * 37);
    rDet    = 5'(1 << (seed % 5)) ^ 5'(seed * 3);
    rSE     = 13'(seed * 977 + 1);
    rST     = 13'(seed * 613 + 2);
  endtask

  task automatic applyRef();
    shieldHit = rShield; detHit = rDet; detVeto = rVeto;
    detPrePile = rPre; detPostPile = rPost;
    detWideE = rWide; detNarrowE = rNarrow; detCrossT = rCross; detFastT = rFast;
    shieldE = rSE; shieldT = rST;
  endtask

  // Runs one event; optionally re-pulses evtValid with other inputs mid-event.
  task automatic runEvent(input bit midPulse);
    applyRef();
    evtValid = 1'b1;
    @(negedge clk);
    evtValid = 1'b0;
    check(busy == 1'b1, "R8", "busy after accept", 32'(busy), 32'd1);
    check(fifoWrEn == 1'b0, "R8", "no write on accept cycle", 32'(fifoWrEn), 32'd0);
    for (int k = 0; k < NI; k++) begin
      bit expEn;
      if (midPulse && k == 2) begin
        evtValid = 1'b1;
        detWideE = ~rWide; detCrossT = ~rCross; detVeto = ~rVeto;
        detPrePile = ~rPre; shieldHit = ~rShield; shieldE = ~rSE;
      end
      if (midPulse && k == 3) evtValid = 1'b0;
      @(negedge clk);
      expEn = rdEnable[k] && !fifoFull;
      check(fifoWrEn == expEn, rdEnable[k] ? (fifoFull ? "R10" : "R8") : "R9",
            $sformatf("write strobe item %0d", k), 32'(fifoWrEn), 32'(expEn));
      if (expEn && fifoWrEn)
        check(fifoWrData == expWord(k), midPulse ? "R11" : reqOf(k),
              $sformatf("word item %0d", k), fifoWrData, expWord(k));
    end
    check(busy == 1'b0, "R8", "busy low after last item", 32'(busy), 32'd0);
    @(negedge clk);
    check(fifoWrEn == 1'b0 && busy == 1'b0, midPulse ? "R11" : "R8",
          "idle after event", {30'd0, busy, fifoWrEn}, 32'd0);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; evtValid = 1'b0; fifoFlush = 1'b0; fifoFull = 1'b0;
    groupId = 8'h00; rdEnable = '1;
    fillRef(0); applyRef();
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R12", "busy in reset", 32'(busy), 32'd0);
    check(fifoWrEn == 1'b0, "R12", "write in reset", 32'(fifoWrEn), 32'd0);
    check(overflowErr == 1'b0, "R12", "error in reset", 32'(overflowErr), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && fifoWrEn == 1'b0, "R12", "idle after reset",
          {30'd0, busy, fifoWrEn}, 32'd0);

    // Flag-combination sweep, all items enabled (R1..R8).
    for (int ev = 0; ev < 8; ev++) begin
      groupId = 8'(ev * 33 + 5);
      fillRef(ev);
      if (ev == 7) begin
        for (int c = 0; c < N; c++) begin
          rWide[c] = 13'h1FFF; rNarrow[c] = 13'h0000;
          rCross[c] = 13'h1FFF; rFast[c] = 13'h1FFF;
        end
        rSE = 13'h1FFF; rST = 13'h0000; rShield = 8'hFF; rDet = 5'h1F;
      end
      runEvent(1'b0);
    end
    check(overflowErr == 1'b0, "R10", "no error without full", 32'(overflowErr), 32'd0);

    // Enable masks (R9).
    rdEnable = NI'(23'h555555); fillRef(9); runEvent(1'b0);
    rdEnable = '0; rdEnable[NI-1] = 1'b1; fillRef(10); runEvent(1'b0);
    rdEnable = '0; fillRef(11); runEvent(1'b0);

    // Snapshot held while inputs and evtValid change mid-event (R11).
    rdEnable = '1; fillRef(12); runEvent(1'b1);

    // FIFO full: drop and sticky flag, then flush (R10).
    fifoFull = 1'b1; fillRef(13); runEvent(1'b0);
    check(overflowErr == 1'b1, "R10", "error set after drop", 32'(overflowErr), 32'd1);
    fifoFull = 1'b0; fillRef(14); runEvent(1'b0);
    check(overflowErr == 1'b1, "R10", "error sticky", 32'(overflowErr), 32'd1);
    fifoFlush = 1'b1;
    @(negedge clk);
    fifoFlush = 1'b0;
    check(overflowErr == 1'b0, "R10", "error cleared by flush", 32'(overflowErr), 32'd0);

    // Full only on a disabled item: no drop.
    rdEnable = '1; rdEnable[3] = 1'b0; fillRef(15);
    applyRef(); evtValid = 1'b1;
    @(negedge clk); evtValid = 1'b0;
    for (int k = 0; k < NI; k++) begin
      fifoFull = (k == 3);
      @(negedge clk);
      check(fifoWrEn == (k != 3), "R9", $sformatf("strobe item %0d", k),
            32'(fifoWrEn), 32'(k != 3));
    end
    fifoFull = 1'b0;
    check(overflowErr == 1'b0, "R10", "no error for disabled item", 32'(overflowErr), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule